// File: doc/BRIEF.md
# Masked Pin-Pattern Event Detector

This block watches one of two 32-bit input ports in the background. It ANDs the chosen port with a programmed mask and compares the result with a programmed target. The block declares an event when the selected condition becomes true after being false. The condition is either "masked value equals target" or "masked value differs from target". Software loads the port choice, the compare sense, the mask, the target and a glitch-filter setting in a single write strobe.

Every event does three things at once. It sets a sticky flag that software can poll and clear. It produces a one-cycle interrupt pulse. It ends any wait that is in progress. A wait holds a stall line high, which the core uses to enter a low-power state. The wait returns one clock after the flag is set, or after an optional timeout with a timeout indication.

Port inputs pass through a two-stage synchronizer before the comparison. With the filter off, an event is reported on the third rising edge after a port change.

Top module: `pin_pattern_event`

## Requirements
- R1: After reset, flag_o, irq_o, stall_o, wait_done_o and wait_timeout_o are all 0. The reset configuration is equal mode, mask 0 and target 0. This configuration always matches, and it never raises an event.
- R2: In equal mode (cfg_not_eq_i=0), the condition is (port & mask) == target. cfg_sel_b_i=1 selects port B and 0 selects port A. When the condition goes from false to true with the filter off, irq_o is high for exactly one cycle and flag_o is set. Both appear on the third rising edge after the port changes. The port that is not selected has no effect.
- R3: In not-equal mode (cfg_not_eq_i=1), the event fires when the masked port value moves from equal to the target to different from it. Changes that keep the masked value equal to the target fire nothing.
- R4: A condition that stays true produces no further events. Leaving the condition and entering it again produces a new event.
- R5: flag_o stays set until a cycle with clr_i high. If clr_i and a new event fall on the same edge, the event wins and flag_o stays 1.
- R6: irq_o pulses for every event, including events that occur while flag_o is already set.
- R7: A configuration write re-seeds the previous-condition state from the new comparison. If the new condition is already true at the write, no event follows.
- R8: cfg_filt_i selects how many consecutive true cycles are needed before an event: 0 needs 1 cycle, 1 needs 2 cycles, 2 and 3 need 3 cycles. A true pulse shorter than the required length produces no event.
- R9: wait_start_i begins a wait. stall_o is high from the next cycle. One cycle after flag_o is seen high, stall_o drops and wait_done_o pulses with wait_timeout_o=0. If flag_o is already set when the wait starts, this return comes one cycle after the start.
- R10: If wait_tmo_i=N is nonzero and no event arrives, stall_o stays high for exactly N cycles. The wait then ends with wait_done_o and wait_timeout_o both pulsing. If N=0, the wait never times out.
- R11: Port bits outside the mask have no effect on the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_a_i | input | 32 | Port A pins, asynchronous |
| port_b_i | input | 32 | Port B pins, asynchronous |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_b_i | input | 1 | Port select, 1 = port B |
| cfg_not_eq_i | input | 1 | Compare sense, 1 = not-equal |
| cfg_filt_i | input | 2 | Filter code, consecutive-cycle count |
| cfg_mask_i | input | 32 | Pins to compare |
| cfg_target_i | input | 32 | Value the masked pins are compared against |
| clr_i | input | 1 | Clear the sticky flag |
| wait_start_i | input | 1 | Begin a wait on the event |
| wait_tmo_i | input | 16 | Wait timeout in cycles, 0 = none |
| flag_o | output | 1 | Sticky event flag |
| irq_o | output | 1 | One-cycle interrupt pulse per event |
| stall_o | output | 1 | Low-power stall while waiting |
| wait_done_o | output | 1 | Wait return pulse |
| wait_timeout_o | output | 1 | Wait ended by timeout, valid with wait_done_o |

## Verification
The comparison is first driven with a masked byte that enters and then leaves its target, while bits outside the mask toggle. This separates a correct mask from a full-width compare, and it separates edge firing from level firing. A second test moves the same pattern first onto the unselected port and then onto the selected one, which shows whether port selection works. A third test changes the value inside the mask in not-equal mode while keeping the masked result equal to the target, which tests the sense inversion. Single-cycle, two-cycle and three-cycle pulses are applied at each filter code to find the exact pulse-length threshold. A clear that lands on the same edge as an event shows which of the two has priority.

// File: rtl/ppe_pkg.sv
package ppe_pkg;

  // Mode bits that travel with every configuration write.
  typedef struct packed {
    logic       sel_b;   // 1: watch port B
    logic       not_eq;  // 1: event when masked value leaves target
    logic [1:0] filt;    // consecutive true cycles required, minus one
  } ppe_mode_t;

  localparam ppe_mode_t PPE_MODE_RESET = '{sel_b: 1'b0, not_eq: 1'b0, filt: 2'd0};

endpackage

// File: rtl/ppe_sync.sv
module ppe_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/ppe_detect.sv
module ppe_detect
  import ppe_pkg::*;
#(
  parameter int W       = 32,
  parameter int MAX_RUN = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pa_i,
  input  logic [W-1:0] pb_i,
  input  logic         cfg_we_i,
  input  ppe_mode_t    mode_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] target_i,
  input  logic         clr_i,
  output logic         irq_o,
  output logic         flag_o
);

  localparam int SAT   = MAX_RUN - 1;
  localparam int RUN_W = (SAT < 2) ? 1 : $clog2(SAT + 1);

  ppe_mode_t      mode_q;
  logic [W-1:0]   mask_q;
  logic [W-1:0]   target_q;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] need_m1;
  logic           prev_q;
  logic           cond_cur;
  logic           cond_new;
  logic           fcond;
  logic           event_c;

  function automatic logic match_fn(input logic [W-1:0] a, input logic [W-1:0] b,
                                    input logic sel_b, input logic not_eq,
                                    input logic [W-1:0] m, input logic [W-1:0] t);
    logic [W-1:0] src;
    src = sel_b ? b : a;
    return (((src & m) == t) ^ not_eq);
  endfunction

  // configuration registers (66 bits of compare state plus filter code)
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= PPE_MODE_RESET;
      mask_q   <= '0;
      target_q <= '0;
    end else if (cfg_we_i) begin
      mode_q   <= mode_i;
      mask_q   <= mask_i;
      target_q <= target_i;
    end
  end

  always_comb begin
    cond_cur = match_fn(pa_i, pb_i, mode_q.sel_b, mode_q.not_eq, mask_q, target_q);
    cond_new = match_fn(pa_i, pb_i, mode_i.sel_b, mode_i.not_eq, mask_i, target_i);
    if (int'(mode_q.filt) > SAT) need_m1 = RUN_W'(SAT);
    else                         need_m1 = RUN_W'(mode_q.filt);
    fcond   = cond_cur && (run_q >= need_m1);
    event_c = fcond && !prev_q && !cfg_we_i;
  end

  // consecutive-true run counter and previous filtered condition
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= RUN_W'(SAT);
      prev_q <= 1'b1;
    end else if (cfg_we_i) begin
      run_q  <= cond_new ? RUN_W'(SAT) : '0;
      prev_q <= cond_new;
    end else begin
      if (!cond_cur)                 run_q <= '0;
      else if (run_q != RUN_W'(SAT)) run_q <= run_q + RUN_W'(1);
      prev_q <= fcond;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o  <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      irq_o  <= event_c;
      flag_o <= event_c | (flag_o & ~clr_i);
    end
  end

  // R6: an event needs a false previous condition, so pulses never abut
  a_r6_irq_single: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);
  // R5: flag is sticky without a clear
  a_r5_flag_holds: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !clr_i) |=> flag_o);
  // R5: an event always leaves the flag set, clear or not
  a_r5_irq_sets_flag: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> flag_o);
  // R7: the write cycle itself never produces an event
  a_r7_no_irq_on_cfg: assert property (@(posedge clk) disable iff (rst)
    cfg_we_i |=> !irq_o);

endmodule

// File: rtl/ppe_wait.sv
module ppe_wait #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [TMO_W-1:0] tmo_i,
  input  logic             flag_i,
  output logic             stall_o,
  output logic             done_o,
  output logic             timeout_o
);

  logic [TMO_W-1:0] cnt_q;
  logic             limited_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stall_o   <= 1'b0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      cnt_q     <= '0;
      limited_q <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      if (!stall_o) begin
        if (start_i) begin
          stall_o   <= 1'b1;
          cnt_q     <= tmo_i;
          limited_q <= (tmo_i != '0);
        end
      end else if (flag_i) begin
        stall_o <= 1'b0;
        done_o  <= 1'b1;
      end else if (limited_q && cnt_q == TMO_W'(1)) begin
        stall_o   <= 1'b0;
        done_o    <= 1'b1;
        timeout_o <= 1'b1;
      end else if (limited_q) begin
        cnt_q <= cnt_q - TMO_W'(1);
      end
    end
  end

  // R9: the stall only ends together with a return
  a_r9_fall_with_done: assert property (@(posedge clk) disable iff (rst)
    $fell(stall_o) |-> done_o);
  // R9: a returned wait is no longer stalling
  a_r9_done_not_stalled: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !stall_o);
  // R10: a timeout indication only accompanies a return
  a_r10_timeout_has_done: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> done_o);
  // R9: an event seen during a wait ends it on the next edge
  a_r9_flag_ends_wait: assert property (@(posedge clk) disable iff (rst)
    (stall_o && flag_i) |=> (done_o && !timeout_o));

endmodule

// File: rtl/pin_pattern_event.sv
module pin_pattern_event
  import ppe_pkg::*;
#(
  parameter int PORT_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int MAX_RUN     = 3,
  parameter int TMO_W       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] port_a_i,
  input  logic [PORT_W-1:0] port_b_i,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_b_i,
  input  logic              cfg_not_eq_i,
  input  logic [1:0]        cfg_filt_i,
  input  logic [PORT_W-1:0] cfg_mask_i,
  input  logic [PORT_W-1:0] cfg_target_i,
  input  logic              clr_i,
  input  logic              wait_start_i,
  input  logic [TMO_W-1:0]  wait_tmo_i,
  output logic              flag_o,
  output logic              irq_o,
  output logic              stall_o,
  output logic              wait_done_o,
  output logic              wait_timeout_o
);

  logic [PORT_W-1:0] pa_s;
  logic [PORT_W-1:0] pb_s;
  ppe_mode_t         mode_in;

  assign mode_in = '{sel_b: cfg_sel_b_i, not_eq: cfg_not_eq_i, filt: cfg_filt_i};

  ppe_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync_a (
    .clk(clk), .rst(rst), .d_i(port_a_i), .q_o(pa_s));

  ppe_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync_b (
    .clk(clk), .rst(rst), .d_i(port_b_i), .q_o(pb_s));

  ppe_detect #(.W(PORT_W), .MAX_RUN(MAX_RUN)) u_detect (
    .clk(clk), .rst(rst),
    .pa_i(pa_s), .pb_i(pb_s),
    .cfg_we_i(cfg_we_i), .mode_i(mode_in),
    .mask_i(cfg_mask_i), .target_i(cfg_target_i),
    .clr_i(clr_i),
    .irq_o(irq_o), .flag_o(flag_o));

  ppe_wait #(.TMO_W(TMO_W)) u_wait (
    .clk(clk), .rst(rst),
    .start_i(wait_start_i), .tmo_i(wait_tmo_i), .flag_i(flag_o),
    .stall_o(stall_o), .done_o(wait_done_o), .timeout_o(wait_timeout_o));

  // R1: no activity is reported on the cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (!irq_o && !flag_o && !stall_o && !wait_done_o));

endmodule

// File: tb/pin_pattern_event_tb.sv
`timescale 1ns/1ps
module pin_pattern_event_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] port_a = '0, port_b = '0;
  logic        cfg_we = 1'b0, cfg_sel_b = 1'b0, cfg_not_eq = 1'b0;
  logic [1:0]  cfg_filt = '0;
  logic [31:0] cfg_mask = '0, cfg_target = '0;
  logic        clr = 1'b0, wait_start = 1'b0;
  logic [15:0] wait_tmo = '0;
  logic        flag, irq, stall, wdone, wtmo;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pin_pattern_event u_dut (
    .clk(clk), .rst(rst), .port_a_i(port_a), .port_b_i(port_b),
    .cfg_we_i(cfg_we), .cfg_sel_b_i(cfg_sel_b), .cfg_not_eq_i(cfg_not_eq),
    .cfg_filt_i(cfg_filt), .cfg_mask_i(cfg_mask), .cfg_target_i(cfg_target),
    .clr_i(clr), .wait_start_i(wait_start), .wait_tmo_i(wait_tmo),
    .flag_o(flag), .irq_o(irq), .stall_o(stall),
    .wait_done_o(wdone), .wait_timeout_o(wtmo));

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input bit sb, input bit ne, input logic [1:0] f,
                     input logic [31:0] m, input logic [31:0] t);
    cfg_we = 1'b1; cfg_sel_b = sb; cfg_not_eq = ne; cfg_filt = f;
    cfg_mask = m; cfg_target = t;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic count_irq(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (irq) c++;
    end
  endtask

  task automatic clear_flag();
    clr = 1'b1; step(1); clr = 1'b0;
  endtask

  task automatic t_reset();
    int c;
    chk(!flag && !irq && !stall && !wdone && !wtmo, "R1 outputs after reset",
        {flag, irq, stall, wdone, wtmo}, 0);
    count_irq(6, c);
    chk(c == 0 && !flag, "R1 reset config raises no event", c, 0);
  endtask

  task automatic t_equal();
    int c;
    port_a = '0;
    cfg(0, 0, 2'd0, 32'h0000_00FF, 32'h0000_005A);
    step(3);
    port_a = 32'h1234_565A;
    step(2);
    chk(irq == 0, "R2 no irq before third edge", irq, 0);
    step(1);
    chk(irq == 1, "R2 irq on equal match", irq, 1);
    chk(flag == 1, "R2 flag set on match", flag, 1);
    step(1);
    chk(irq == 0, "R2 irq lasts one cycle", irq, 0);
    count_irq(6, c);
    chk(c == 0, "R4 held match gives no repeat", c, 0);
    port_a = 32'hFFFF_FF5A;
    count_irq(6, c);
    chk(c == 0, "R11 unmasked bits ignored", c, 0);
    port_a = '0; step(4);
    port_a = 32'h0000_005A; step(3);
    chk(irq == 1, "R4 re-entry fires again / R6 irq with flag set", irq, 1);
    chk(flag == 1, "R6 flag still set", flag, 1);
    clear_flag();
    chk(flag == 0, "R5 clear drops flag", flag, 0);
  endtask

  task automatic t_portb();
    int c;
    port_a = '0; port_b = '0;
    cfg(1, 0, 2'd0, 32'hFFFF_FFFF, 32'hCAFE_0001);
    step(3);
    port_a = 32'hCAFE_0001;
    count_irq(6, c);
    chk(c == 0 && !flag, "R2 unselected port A ignored", c, 0);
    port_b = 32'hCAFE_0001;
    step(3);
    chk(irq == 1, "R2 port B match fires", irq, 1);
    clear_flag();
    port_b = '0;
  endtask

  task automatic t_noteq();
    int c;
    port_a = 32'h0000_0003;
    cfg(0, 1, 2'd0, 32'h0000_000F, 32'h0000_0003);
    count_irq(4, c);
    chk(c == 0, "R3 equal value gives no not-equal event", c, 0);
    port_a = 32'h0000_0013;
    count_irq(5, c);
    chk(c == 0, "R3 masked still equal, no event", c, 0);
    port_a = 32'h0000_0007;
    step(3);
    chk(irq == 1, "R3 leaving target fires", irq, 1);
    chk(flag == 1, "R3 flag set", flag, 1);
    clear_flag();
  endtask

  task automatic t_reseed();
    int c;
    port_a = 32'h0000_005A;
    step(4);
    clear_flag();
    cfg(0, 0, 2'd0, 32'h0000_00FF, 32'h0000_005A);
    count_irq(8, c);
    chk(c == 0, "R7 config already matching gives no event", c, 0);
    chk(flag == 0, "R7 flag stays clear", flag, 0);
  endtask

  task automatic t_collide();
    port_a = '0;
    cfg(0, 0, 2'd0, 32'h0000_00FF, 32'h0000_005A);
    step(3);
    port_a = 32'h0000_005A;
    step(2);
    clr = 1'b1;
    step(1);
    clr = 1'b0;
    chk(irq == 1, "R5 event on clear edge", irq, 1);
    chk(flag == 1, "R5 event wins over clear", flag, 1);
    clear_flag();
    chk(flag == 0, "R5 later clear works", flag, 0);
  endtask

  task automatic pulse(input int len, output int c);
    port_a = 32'h1;
    step(len);
    port_a = '0;
    count_irq(10, c);
  endtask

  task automatic t_filter();
    int c;
    port_a = '0;
    cfg(0, 0, 2'd1, 32'h1, 32'h1); step(3);
    pulse(1, c); chk(c == 0, "R8 code1 rejects 1-cycle pulse", c, 0);
    pulse(2, c); chk(c == 1, "R8 code1 accepts 2-cycle pulse", c, 1);
    port_a = 32'h1; step(3);
    chk(irq == 0, "R8 code1 not yet at third edge", irq, 0);
    step(1);
    chk(irq == 1, "R8 code1 fires on fourth edge", irq, 1);
    port_a = '0; step(4);
    cfg(0, 0, 2'd2, 32'h1, 32'h1); step(3);
    pulse(2, c); chk(c == 0, "R8 code2 rejects 2-cycle pulse", c, 0);
    pulse(3, c); chk(c == 1, "R8 code2 accepts 3-cycle pulse", c, 1);
    cfg(0, 0, 2'd3, 32'h1, 32'h1); step(3);
    pulse(2, c); chk(c == 0, "R8 code3 rejects 2-cycle pulse", c, 0);
    cfg(0, 0, 2'd0, 32'h1, 32'h1); step(3);
    pulse(1, c); chk(c == 1, "R8 code0 accepts 1-cycle pulse", c, 1);
    clear_flag();
  endtask

  task automatic t_wait_event();
    port_a = '0;
    cfg(0, 0, 2'd0, 32'h0000_00FF, 32'h0000_005A);
    step(3);
    clear_flag();
    wait_tmo = '0; wait_start = 1'b1; step(1); wait_start = 1'b0;
    chk(stall == 1, "R9 stall after start", stall, 1);
    step(40);
    chk(stall == 1 && !wdone, "R10 zero timeout keeps waiting", stall, 1);
    port_a = 32'h0000_005A;
    step(3);
    chk(flag == 1 && stall == 1, "R9 still stalled on flag cycle", stall, 1);
    step(1);
    chk(wdone == 1 && wtmo == 0 && stall == 0, "R9 return after flag",
        {wdone, wtmo, stall}, 3'b100);
    step(1);
    chk(wdone == 0, "R9 done is a pulse", wdone, 0);
    wait_start = 1'b1; step(1); wait_start = 1'b0;
    chk(stall == 1, "R9 stall with flag preset", stall, 1);
    step(1);
    chk(wdone == 1 && wtmo == 0, "R9 preset flag returns next cycle", wdone, 1);
    clear_flag();
  endtask

  task automatic t_timeout(input int n);
    int c = 0;
    port_a = '0;
    step(4);
    clear_flag();
    wait_tmo = 16'(n); wait_start = 1'b1; step(1); wait_start = 1'b0;
    while (stall && c < 100) begin
      c++;
      step(1);
    end
    chk(c == n, "R10 stall length equals timeout", c, n);
    chk(wdone == 1 && wtmo == 1, "R10 timeout indication", {wdone, wtmo}, 2'b11);
    step(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_equal();
    t_portb();
    t_noteq();
    t_reseed();
    t_collide();
    t_filter();
    t_wait_event();
    t_timeout(5);
    t_timeout(1);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule